// File: doc/BRIEF.md
# Fast-to-Slow Bus Access Synchronizer

This block sits between a fast CPU core and a slow legacy peripheral bus. The slow bus runs at a fixed integer fraction of the CPU clock, set by the parameter `RATIO`. An internal phase counter divides the CPU clock and drives a one-cycle `sb_strobe` that marks the first CPU cycle of each slow-bus cycle. Each CPU request is checked against a hardware-register window (`HW_BASE`/`HW_MASK`) and sent one of two ways:
- **Outside the window:** the request goes to a fast local memory. It completes in the cycle it is presented.
- **Inside the window:** the request is held until the next slow-cycle start. It then occupies one slow cycle per byte. A word access runs its low byte and then its high byte on two consecutive slow cycles.

A display engine can read the fast memory through its own port. That read owns the fast-memory port for one cycle. A CPU fast access presented in the same cycle waits one cycle. A display read does not disturb a slow access already in progress.

The CPU port is a valid/ready handshake, and a transfer completes in the cycle where both are high. Once `cpu_valid` is raised, it and every request field must stay stable until that cycle. The bridge applies back-pressure by holding `cpu_ready` low. Fast memory is assumed to return read data combinationally in the same cycle as `fm_en`. The display read is not flow-controlled: `dsp_rdata` is valid in the cycle `dsp_valid` is high.

Top module: `bus_sync_bridge`

## Requirements
- R1: A CPU request outside the window, with no display read in the same cycle, gets `cpu_ready` high in the cycle it is presented. `fm_en` is high and `fm_addr` carries `cpu_addr`. A byte read returns `{8'h00, fm_rdata[7:0]}` and a word read returns `fm_rdata`, with the low byte at the request address.
- R2: After reset is released, `sb_strobe` is high in the first cycle and then once every `RATIO` cycles, and low in all other cycles.
- R3: A slow-bus cycle (`sb_cyc` high) only begins in a cycle where `sb_strobe` is high. A window request first seen in any other cycle waits for the next strobe. A request presented in a strobe cycle starts in that cycle.
- R4: A byte access inside the window holds `sb_cyc` high for exactly `RATIO` cycles. `cpu_ready` stays low from the request until the last of those cycles, and is high in that last cycle.
- R5: A read inside the window returns the `sb_rdata` value present in the last cycle of each slow cycle. A byte read returns `{8'h00, byte}`. A word read returns `{high byte, low byte}`.
- R6: A word access inside the window runs two slow cycles back to back, with no gap between them. The first uses `cpu_addr` and the low data byte; the second uses `cpu_addr+1` and the high data byte. `cpu_ready` is high only in the final cycle of the second slow cycle.
- R7: Two byte writes inside the window, separated by one fast access, start exactly `2*RATIO` cycles apart.
- R8: A display read takes priority over a CPU fast access in the same cycle. That cycle has `fm_en` high, `fm_addr` equal to `dsp_addr`, `fm_we` low, `dsp_rdata` equal to `fm_rdata[7:0]` and `cpu_ready` low. The CPU access then completes one cycle later.
- R9: A display read during a slow access returns fast-memory data in that cycle, and the slow access finishes in the same cycle it would have finished without the read.
- R10: An address goes to the slow bus exactly when `(addr & HW_MASK) == HW_BASE`. With the default window `16'hD000`/`16'hFF00`, `D0FF` is slow while `D100` and `CFFF` are fast. A request outside the window never raises `sb_cyc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_valid | input | 1 | CPU request present |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_addr | input | ADDR_W | Request address |
| cpu_word | input | 1 | 1 = two-byte access, 0 = byte |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 2*BYTE_W | Write data, low byte at `cpu_addr` |
| cpu_rdata | output | 2*BYTE_W | Read data, valid with `cpu_ready` |
| fm_en | output | 1 | Fast memory access this cycle |
| fm_we | output | 1 | Fast memory write |
| fm_word | output | 1 | Fast memory two-byte access |
| fm_addr | output | ADDR_W | Fast memory address |
| fm_wdata | output | 2*BYTE_W | Fast memory write data |
| fm_rdata | input | 2*BYTE_W | Fast memory read data (same cycle) |
| dsp_valid | input | 1 | Display read request |
| dsp_addr | input | ADDR_W | Display read address |
| dsp_rdata | output | BYTE_W | Display read data |
| sb_strobe | output | 1 | First CPU cycle of a slow-bus cycle |
| sb_cyc | output | 1 | Slow-bus cycle in use by a CPU access |
| sb_we | output | 1 | Slow-bus write |
| sb_addr | output | ADDR_W | Slow-bus byte address |
| sb_wdata | output | BYTE_W | Slow-bus write byte |
| sb_rdata | input | BYTE_W | Slow-bus read byte |

## Verification
Each fault in the phase counter or the slow sequencer shows up at the ports within one slow cycle:
- **Wrong phase counter value:** `sb_strobe` appears a cycle off its `RATIO` grid, and every later slow access starts and completes in the wrong cycle.
- **Stuck byte-index flag:** a word access either ends after one slow cycle or repeats the low-byte address. This is visible at `sb_addr` on the second strobe and in the cycle `cpu_ready` rises.
- **Dropped or stale read-byte latch:** the upper half of a word read is corrupted in the completion cycle.
- **Wrong arbitration select:** `fm_addr` shows the CPU address under a display read, or `cpu_ready` rises in the conflict cycle.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
  // Owner of the fast-memory port in the current cycle.
  typedef enum logic [1:0] {
    FM_IDLE = 2'd0,
    FM_CPU  = 2'd1,
    FM_DSP  = 2'd2
  } fm_src_e;
endpackage

// File: rtl/bsb_phase_gen.sv
// Divides the CPU clock into slow-bus cycles of RATIO CPU cycles each.
module bsb_phase_gen #(
  parameter int RATIO = 12
) (
  input  logic clk,
  input  logic rst,
  output logic strobe,
  output logic last
);
  localparam int PH_W = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATIO - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst)                ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                    ph_q <= ph_q + 1'b1;
  end

  assign strobe = (ph_q == '0);
  assign last   = (ph_q == PH_LAST);
endmodule

// File: rtl/bsb_decode.sv
// Window match for the hardware-register region.
module bsb_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] HW_BASE = 16'hD000,
  parameter logic [ADDR_W-1:0] HW_MASK = 16'hFF00
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_hw
);
  assign is_hw = ((addr & HW_MASK) == HW_BASE);
endmodule

// File: rtl/bsb_slow_seq.sv
// Runs one slow-bus cycle per byte, starting only on a strobe.
module bsb_slow_seq #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                strobe,
  input  logic                last,
  input  logic                req,
  input  logic                word,
  input  logic                we,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [2*BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0]   sb_rdata,
  output logic                sb_cyc,
  output logic                sb_we,
  output logic [ADDR_W-1:0]   sb_addr,
  output logic [BYTE_W-1:0]   sb_wdata,
  output logic                done,
  output logic [2*BYTE_W-1:0] rdata
);
  logic              cyc_q;   // slow cycle owned after its first phase
  logic              idx_q;   // 0 = low byte, 1 = high byte of a word
  logic [BYTE_W-1:0] lo_q;    // low byte captured for word reads
  logic              live;

  // A cycle is live from its strobe phase through its last phase.
  assign live = cyc_q | (strobe & req);

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= 1'b0;
      idx_q <= 1'b0;
      lo_q  <= '0;
    end else begin
      if (strobe)    cyc_q <= req;
      else if (last) cyc_q <= 1'b0;
      if (live && last) begin
        lo_q  <= sb_rdata;
        idx_q <= word & ~idx_q;
      end
    end
  end

  assign sb_cyc   = live;
  assign sb_we    = live & we;
  assign sb_addr  = addr + ADDR_W'(idx_q);
  assign sb_wdata = idx_q ? wdata[2*BYTE_W-1:BYTE_W] : wdata[BYTE_W-1:0];
  assign done     = live & last & (~word | idx_q);
  assign rdata    = word ? {sb_rdata, lo_q} : {{BYTE_W{1'b0}}, sb_rdata};
endmodule

// File: rtl/bsb_fast_arb.sv
// Shares the fast-memory port; the display read wins a conflict.
module bsb_fast_arb
  import bsb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic                cpu_fast,
  input  logic                cpu_word,
  input  logic                cpu_we,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic [2*BYTE_W-1:0] cpu_wdata,
  input  logic                dsp_valid,
  input  logic [ADDR_W-1:0]   dsp_addr,
  input  logic [2*BYTE_W-1:0] fm_rdata,
  output logic                fm_en,
  output logic                fm_we,
  output logic                fm_word,
  output logic [ADDR_W-1:0]   fm_addr,
  output logic [2*BYTE_W-1:0] fm_wdata,
  output logic                fast_done,
  output logic [2*BYTE_W-1:0] fast_rdata,
  output logic [BYTE_W-1:0]   dsp_rdata
);
  fm_src_e src;

  always_comb begin
    if (dsp_valid)     src = FM_DSP;
    else if (cpu_fast) src = FM_CPU;
    else               src = FM_IDLE;
  end

  always_comb begin
    fm_en    = (src != FM_IDLE);
    fm_we    = (src == FM_CPU) & cpu_we;
    fm_word  = (src == FM_CPU) & cpu_word;
    fm_addr  = (src == FM_DSP) ? dsp_addr : cpu_addr;
    fm_wdata = cpu_wdata;
  end

  assign fast_done  = (src == FM_CPU);
  assign fast_rdata = cpu_word ? fm_rdata : {{BYTE_W{1'b0}}, fm_rdata[BYTE_W-1:0]};
  assign dsp_rdata  = fm_rdata[BYTE_W-1:0];
endmodule

// File: rtl/bus_sync_bridge.sv
// Top: routes CPU requests to fast memory or the slow peripheral bus.
module bus_sync_bridge #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int RATIO  = 12,
  parameter logic [ADDR_W-1:0] HW_BASE = 16'hD000,
  parameter logic [ADDR_W-1:0] HW_MASK = 16'hFF00
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cpu_valid,
  output logic                cpu_ready,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                cpu_word,
  input  logic                cpu_we,
  input  logic [2*BYTE_W-1:0] cpu_wdata,
  output logic [2*BYTE_W-1:0] cpu_rdata,
  output logic                fm_en,
  output logic                fm_we,
  output logic                fm_word,
  output logic [ADDR_W-1:0]   fm_addr,
  output logic [2*BYTE_W-1:0] fm_wdata,
  input  logic [2*BYTE_W-1:0] fm_rdata,
  input  logic                dsp_valid,
  input  logic [ADDR_W-1:0]   dsp_addr,
  output logic [BYTE_W-1:0]   dsp_rdata,
  output logic                sb_strobe,
  output logic                sb_cyc,
  output logic                sb_we,
  output logic [ADDR_W-1:0]   sb_addr,
  output logic [BYTE_W-1:0]   sb_wdata,
  input  logic [BYTE_W-1:0]   sb_rdata
);
  localparam int WORD_W = 2 * BYTE_W;

  logic              is_hw;
  logic              ph_last;
  logic              slow_done;
  logic              fast_done;
  logic [WORD_W-1:0] slow_rdata;
  logic [WORD_W-1:0] fast_rdata;

  bsb_decode #(
    .ADDR_W(ADDR_W), .HW_BASE(HW_BASE), .HW_MASK(HW_MASK)
  ) u_dec (
    .addr(cpu_addr), .is_hw(is_hw)
  );

  bsb_phase_gen #(.RATIO(RATIO)) u_ph (
    .clk(clk), .rst(rst), .strobe(sb_strobe), .last(ph_last)
  );

  bsb_slow_seq #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_slow (
    .clk(clk), .rst(rst),
    .strobe(sb_strobe), .last(ph_last),
    .req(cpu_valid & is_hw), .word(cpu_word), .we(cpu_we),
    .addr(cpu_addr), .wdata(cpu_wdata), .sb_rdata(sb_rdata),
    .sb_cyc(sb_cyc), .sb_we(sb_we), .sb_addr(sb_addr), .sb_wdata(sb_wdata),
    .done(slow_done), .rdata(slow_rdata)
  );

  bsb_fast_arb #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_arb (
    .cpu_fast(cpu_valid & ~is_hw), .cpu_word(cpu_word), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .dsp_valid(dsp_valid), .dsp_addr(dsp_addr), .fm_rdata(fm_rdata),
    .fm_en(fm_en), .fm_we(fm_we), .fm_word(fm_word), .fm_addr(fm_addr),
    .fm_wdata(fm_wdata), .fast_done(fast_done), .fast_rdata(fast_rdata),
    .dsp_rdata(dsp_rdata)
  );

  assign cpu_ready = fast_done | slow_done;
  assign cpu_rdata = is_hw ? slow_rdata : fast_rdata;
endmodule

// File: rtl/bsb_checker.sv
// Temporal checks for bus_sync_bridge, attached by bind below.
module bsb_checker #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int RATIO  = 12,
  parameter logic [ADDR_W-1:0] HW_BASE = 16'hD000,
  parameter logic [ADDR_W-1:0] HW_MASK = 16'hFF00
) (
  input logic                clk,
  input logic                rst,
  input logic                cpu_valid,
  input logic                cpu_ready,
  input logic [ADDR_W-1:0]   cpu_addr,
  input logic                cpu_word,
  input logic                cpu_we,
  input logic                fm_en,
  input logic                fm_we,
  input logic [ADDR_W-1:0]   fm_addr,
  input logic                dsp_valid,
  input logic [ADDR_W-1:0]   dsp_addr,
  input logic                sb_strobe,
  input logic                sb_cyc
);
  localparam int CW = $clog2(RATIO + 2) + 1;

  logic          hw;
  logic [CW-1:0] since_q;
  logic          seen_q;

  assign hw = ((cpu_addr & HW_MASK) == HW_BASE);

  // Cycles since the last strobe, saturating past RATIO.
  always_ff @(posedge clk) begin
    if (rst) begin
      since_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      seen_q <= seen_q | sb_strobe;
      if (sb_strobe)                   since_q <= CW'(1);
      else if (since_q <= CW'(RATIO))  since_q <= since_q + 1'b1;
    end
  end

  initial assert (RATIO >= 2) else $error("RATIO must be at least 2");

  p_fast_same_cycle_r1: assert property (@(posedge clk) disable iff (rst)
    cpu_valid && !hw && !dsp_valid |-> cpu_ready && fm_en && fm_addr == cpu_addr);

  p_strobe_gap_r2: assert property (@(posedge clk) disable iff (rst)
    seen_q && since_q != CW'(RATIO) |-> !sb_strobe);

  p_strobe_due_r2: assert property (@(posedge clk) disable iff (rst)
    seen_q && since_q == CW'(RATIO) |-> sb_strobe);

  p_start_on_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    seen_q && sb_cyc && !$past(sb_cyc) |-> sb_strobe);

  p_ready_before_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_valid && hw && cpu_ready |=> sb_strobe);

  p_no_ready_idle_r4: assert property (@(posedge clk) disable iff (rst)
    cpu_valid && hw && !sb_cyc |-> !cpu_ready);

  p_word_no_gap_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_valid && hw && cpu_word && sb_cyc && !cpu_ready |=> sb_cyc);

  p_dsp_owns_port_r8: assert property (@(posedge clk) disable iff (rst)
    dsp_valid |-> fm_en && fm_addr == dsp_addr && !fm_we);

  p_dsp_holds_cpu_r8: assert property (@(posedge clk) disable iff (rst)
    dsp_valid && cpu_valid && !hw |-> !cpu_ready);

  p_fast_no_slow_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_valid && !hw |-> !sb_cyc);
endmodule

bind bus_sync_bridge bsb_checker #(
  .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .RATIO(RATIO),
  .HW_BASE(HW_BASE), .HW_MASK(HW_MASK)
) u_chk (
  .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
  .cpu_addr(cpu_addr), .cpu_word(cpu_word), .cpu_we(cpu_we),
  .fm_en(fm_en), .fm_we(fm_we), .fm_addr(fm_addr),
  .dsp_valid(dsp_valid), .dsp_addr(dsp_addr),
  .sb_strobe(sb_strobe), .sb_cyc(sb_cyc)
);

// File: tb/bus_sync_bridge_tb.sv
module bus_sync_bridge_tb;
  localparam int RATIO = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_valid = 1'b0, cpu_word = 1'b0, cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [15:0] cpu_rdata;
  logic        fm_en, fm_we, fm_word;
  logic [15:0] fm_addr, fm_wdata, fm_rdata;
  logic        dsp_valid = 1'b0;
  logic [15:0] dsp_addr = '0;
  logic [7:0]  dsp_rdata;
  logic        sb_strobe, sb_cyc, sb_we;
  logic [15:0] sb_addr;
  logic [7:0]  sb_wdata, sb_rdata;

  always #2 clk = ~clk;

  bus_sync_bridge u_dut (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
    .cpu_word(cpu_word), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .fm_en(fm_en), .fm_we(fm_we), .fm_word(fm_word), .fm_addr(fm_addr),
    .fm_wdata(fm_wdata), .fm_rdata(fm_rdata),
    .dsp_valid(dsp_valid), .dsp_addr(dsp_addr), .dsp_rdata(dsp_rdata),
    .sb_strobe(sb_strobe), .sb_cyc(sb_cyc), .sb_we(sb_we), .sb_addr(sb_addr),
    .sb_wdata(sb_wdata), .sb_rdata(sb_rdata)
  );

  // Memory models on both sides, and mirrors of their expected contents.
  logic [7:0] fmem [0:1023];
  logic [7:0] pmem [0:255];
  logic [7:0] ref_f [0:1023];
  logic [7:0] ref_p [0:255];
  logic [9:0] fa0, fa1;
  assign fa0 = fm_addr[9:0];
  assign fa1 = fm_addr[9:0] + 10'd1;
  assign fm_rdata = {fmem[fa1], fmem[fa0]};
  assign sb_rdata = pmem[sb_addr[7:0]];

  always @(posedge clk) begin
    if (fm_en && fm_we) begin
      fmem[fa0] <= fm_wdata[7:0];
      if (fm_word) fmem[fa1] <= fm_wdata[15:8];
    end
    if (sb_cyc && sb_we && sb_strobe) pmem[sb_addr[7:0]] <= sb_wdata;
  end

  // Bench time base: cycle count and slow-bus phase since reset release.
  int ccount = 0;
  int bph = 0;
  always @(posedge clk) begin
    if (!rst) begin
      ccount <= ccount + 1;
      bph    <= (bph == RATIO - 1) ? 0 : bph + 1;
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  typedef struct { int cyc; logic [15:0] addr; logic we; logic [7:0] data; string tag; } beat_t;
  typedef struct { int cyc; logic [15:0] data; string tag; } rsp_t;
  beat_t exp_beats[$];
  rsp_t  exp_rsps[$];
  int last_beat = 0, prev_beat = 0;

  // Monitor: compares what the design produces against the queues.
  always @(negedge clk) begin
    if (!rst) begin
      check(sb_strobe == (bph == 0), "R2", "strobe", 32'(sb_strobe), 32'(bph == 0));
      if (sb_strobe && sb_cyc) begin
        prev_beat = last_beat;
        last_beat = ccount;
        if (exp_beats.size() == 0) begin
          check(1'b0, "R3", "unexpected slow beat", 32'(ccount), 0);
        end else begin
          beat_t b;
          b = exp_beats.pop_front();
          check(ccount == b.cyc, b.tag, "beat start cycle", 32'(ccount), 32'(b.cyc));
          check(sb_addr == b.addr, b.tag, "beat addr", 32'(sb_addr), 32'(b.addr));
          check(sb_we == b.we, b.tag, "beat we", 32'(sb_we), 32'(b.we));
          if (b.we) check(sb_wdata == b.data, b.tag, "beat wdata", 32'(sb_wdata), 32'(b.data));
        end
      end
      if (cpu_valid && cpu_ready) begin
        if (exp_rsps.size() == 0) begin
          check(1'b0, "R1", "unexpected ready", 32'(ccount), 0);
        end else begin
          rsp_t r;
          r = exp_rsps.pop_front();
          check(ccount == r.cyc, r.tag, "ready cycle", 32'(ccount), 32'(r.cyc));
          if (!cpu_we) check(cpu_rdata == r.data, r.tag, "rdata", 32'(cpu_rdata), 32'(r.data));
        end
      end
    end
  end

  function automatic bit in_win(input logic [15:0] a);
    return (a & 16'hFF00) == 16'hD000;
  endfunction

  // Driver: enter at posedge+1, leave at posedge+1 after the transfer.
  task automatic access(input logic [15:0] addr, input bit word, input bit we,
                        input logic [15:0] wdata, input bit dsp,
                        input logic [15:0] daddr, input string tag);
    int issue, w, nb;
    logic [15:0] rd;
    rsp_t r;
    issue = ccount;
    if (in_win(addr)) begin
      w  = (bph == 0) ? 0 : RATIO - bph;
      nb = word ? 2 : 1;
      rd = word ? {ref_p[8'(addr[7:0] + 8'd1)], ref_p[addr[7:0]]} : {8'h00, ref_p[addr[7:0]]};
      for (int k = 0; k < nb; k++) begin
        beat_t b;
        b.cyc = issue + w + k * RATIO; b.addr = addr + 16'(k); b.we = we;
        b.data = (k == 0) ? wdata[7:0] : wdata[15:8]; b.tag = tag;
        exp_beats.push_back(b);
        if (we) ref_p[8'(addr[7:0] + 8'(k))] = b.data;
      end
      r.cyc = issue + w + nb * RATIO - 1;
    end else begin
      rd = word ? {ref_f[addr[9:0] + 10'd1], ref_f[addr[9:0]]} : {8'h00, ref_f[addr[9:0]]};
      if (we) begin
        ref_f[addr[9:0]] = wdata[7:0];
        if (word) ref_f[addr[9:0] + 10'd1] = wdata[15:8];
      end
      r.cyc = issue + (dsp ? 1 : 0);
    end
    r.data = rd; r.tag = tag;
    exp_rsps.push_back(r);
    cpu_addr = addr; cpu_word = word; cpu_we = we; cpu_wdata = wdata; cpu_valid = 1'b1;
    if (dsp) begin dsp_addr = daddr; dsp_valid = 1'b1; end
    @(negedge clk);
    if (dsp) begin
      check(fm_addr == daddr && fm_en && !fm_we, "R8", "display owns port",
            32'(fm_addr), 32'(daddr));
      check(dsp_rdata == ref_f[daddr[9:0]], "R8", "display data",
            32'(dsp_rdata), 32'(ref_f[daddr[9:0]]));
      check(!cpu_ready, "R8", "cpu held", 32'(cpu_ready), 0);
      @(posedge clk); #1 dsp_valid = 1'b0;
      @(negedge clk);
    end
    while (!cpu_ready) @(negedge clk);
    @(posedge clk); #1 cpu_valid = 1'b0;
  endtask

  task automatic pulse_dsp(input int dly, input logic [15:0] daddr);
    repeat (dly) @(posedge clk);
    #1 dsp_addr = daddr; dsp_valid = 1'b1;
    @(negedge clk);
    check(fm_en && fm_addr == daddr, "R9", "display addr in slow access", 32'(fm_addr), 32'(daddr));
    check(dsp_rdata == ref_f[daddr[9:0]], "R9", "display data in slow access",
          32'(dsp_rdata), 32'(ref_f[daddr[9:0]]));
    @(posedge clk); #1 dsp_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) begin fmem[i] = 8'(i * 7 + 3); ref_f[i] = 8'(i * 7 + 3); end
    for (int i = 0; i < 256; i++)  begin pmem[i] = 8'(i ^ 8'hA5); ref_p[i] = 8'(i ^ 8'hA5); end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!cpu_ready && !sb_cyc && !fm_en, "R4", "reset idle outputs",
          {29'd0, cpu_ready, sb_cyc, fm_en}, 0);
    @(posedge clk); #1 rst = 1'b0;

    // R1: fast byte read, word write, word read
    access(16'h0010, 0, 0, 16'h0000, 0, 16'h0, "R1");
    access(16'h0020, 1, 1, 16'hBEEF, 0, 16'h0, "R1");
    access(16'h0020, 1, 0, 16'h0000, 0, 16'h0, "R1");
    // R3 R4: byte write at an odd phase, then read back (R5)
    idle(3);
    access(16'hD005, 0, 1, 16'h005A, 0, 16'h0, "R4");
    idle(5);
    access(16'hD005, 0, 0, 16'h0000, 0, 16'h0, "R5");
    // R6: word write and word read
    idle(1);
    access(16'hD010, 1, 1, 16'h1234, 0, 16'h0, "R6");
    access(16'hD010, 1, 0, 16'h0000, 0, 16'h0, "R6");
    // R3: window write directly after another starts on the very next strobe
    access(16'hD030, 0, 1, 16'h0011, 0, 16'h0, "R3");
    access(16'hD031, 0, 1, 16'h0022, 0, 16'h0, "R3");
    check(last_beat - prev_beat == RATIO, "R3", "no-gap spacing",
          32'(last_beat - prev_beat), 32'(RATIO));
    // R7: byte write, one fast access, byte write
    access(16'hD020, 0, 1, 16'h0077, 0, 16'h0, "R7");
    access(16'h0030, 0, 0, 16'h0000, 0, 16'h0, "R7");
    access(16'hD021, 0, 1, 16'h0088, 0, 16'h0, "R7");
    check(last_beat - prev_beat == 2 * RATIO, "R7", "every other slow cycle",
          32'(last_beat - prev_beat), 32'(2 * RATIO));
    // R8: display read collides with a CPU fast read
    idle(2);
    access(16'h0040, 0, 0, 16'h0000, 1, 16'h0055, "R8");
    access(16'h0044, 1, 1, 16'hCAFE, 1, 16'h0066, "R8");
    // R9: display read in the middle of a slow word read
    idle(4);
    fork
      access(16'hD010, 1, 0, 16'h0000, 0, 16'h0, "R9");
      pulse_dsp(5, 16'h0070);
    join
    // R10: window edges
    access(16'hD0FF, 0, 1, 16'h00C3, 0, 16'h0, "R10");
    access(16'hD100, 0, 0, 16'h0000, 0, 16'h0, "R10");
    access(16'hCFFF, 0, 0, 16'h0000, 0, 16'h0, "R10");
    access(16'hD0FF, 1, 1, 16'h9A5B, 0, 16'h0, "R10");
    access(16'hD0FF, 1, 0, 16'h0000, 0, 16'h0, "R10");
    idle(2);
    check(exp_beats.size() == 0, "R3", "beats left over", 32'(exp_beats.size()), 0);
    check(exp_rsps.size() == 0, "R1", "responses left over", 32'(exp_rsps.size()), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R4 watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule